// File: doc/BRIEF.md
# Switched-Capacitor Sampler Readout Sequencer

This block runs a switched-capacitor sampling chip through an endless series of acquire-and-read cycles. Out of reset it programs two 8-bit setup registers in the chip. It shifts each word out serially while it holds the register's address on the address pins. It then lets the sampling ring run with writing enabled and waits for a trigger. When the trigger arrives it stops writing, which freezes the stored samples.

After the freeze it pulses the strobe that makes the chip latch its stop position. It then selects the all-channel readout address and issues a programmed number of serial clock pulses. During the first ten of those pulses it shifts the 10-bit stop position in from the chip's serial output. After every pulse it strobes the external converter once. When the last pulse has finished it returns to waiting for a trigger and does not repeat the setup.

High time, low time, strobe width and pulse count are plain input pins, so firmware can retune the timing between acquisitions. The stop position leaves the block as a one-cycle valid pulse with no ready signal. A consumer must take it in the cycle it appears, because the value is never held back for it.

Top module: `scs_readout_seq`

## Requirements
- R1: While reset is low, every output is low, `chip_addr_o` is 4'b0000 and `busy_o` is low.
- R2: After reset the block writes CFG_WORD (default 8'hFF) at address 4'b1100, then WSR_WORD (default 8'hFF) at address 4'b1101. Each word is 8 `sclk_o` pulses, MSB first. `sdata_o` holds the current bit through each high phase, and the address stays stable. `sdata_o` is low outside the setup.
- R3: Each `sclk_o` pulse is high for `hi_cycles_i` clocks and then low for `lo_cycles_i` clocks, and a value of 0 counts as 1.
- R4: Once setup ends, `run_o` and `write_o` are high with address 4'b0000. When `trig_i` is sampled high there, the next cycle has `write_o` low and no load strobe: this is the freeze cycle.
- R5: `stop_load_o` is high for max(`load_cycles_i`, 2) cycles, starting right after the freeze cycle.
- R6: After the strobe, the address is 4'b1001 and max(`shift_count_i`, 10) `sclk_o` pulses follow, with `run_o` high and `write_o` low.
- R7: `sdata_i` is sampled in the first high cycle of each of the first 10 readout pulses, MSB first. `stop_pos_o` updates, and `stop_valid_o` is high for one cycle, in the cycle after the 10th sample. `stop_pos_o` then holds its value.
- R8: `adc_conv_o` is high for one cycle, two cycles after the last high cycle of each readout pulse, and never during setup.
- R9: `busy_o` is high from the freeze cycle through the last low cycle of readout. A trigger seen while busy has no effect on the sequence.
- R10: After readout the block goes straight back to the waiting state of R4, without repeating the setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger level, sampled only while waiting |
| hi_cycles_i | input | 4 | Serial clock high time in clocks |
| lo_cycles_i | input | 4 | Serial clock low time in clocks |
| load_cycles_i | input | 4 | Stop-load strobe width in clocks |
| shift_count_i | input | 12 | Readout pulse count |
| sdata_i | input | 1 | Serial data from the chip |
| chip_addr_o | output | 4 | Chip address pins |
| run_o | output | 1 | Sampling ring enable |
| write_o | output | 1 | Sample write enable |
| stop_load_o | output | 1 | Stop-position load strobe |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data to the chip |
| adc_conv_o | output | 1 | Converter start strobe |
| busy_o | output | 1 | Acquisition in progress |
| stop_pos_o | output | 10 | Captured stop position |
| stop_valid_o | output | 1 | One-cycle valid for `stop_pos_o` |

## Verification
With a low time of one clock, the converter strobe for the last readout pulse lands in the first waiting cycle. That cycle is also the first one in which a new trigger can be sampled. The bench provokes the overlap by holding the trigger high through a readout and ending it with a one-clock low phase. A cycle-by-cycle model then expects both the strobe in that waiting cycle and a freeze cycle directly after it. A second overlap occurs when a trigger held high during busy must be ignored while the stop position is still being shifted in; the model expects the full, unchanged sequence in that case.

// File: rtl/scs_seq_pkg.sv
package scs_seq_pkg;
  typedef enum logic [2:0] {
    ST_INIT,
    ST_CFG0,
    ST_CFG1,
    ST_ARM,
    ST_FREEZE,
    ST_LOAD,
    ST_READ
  } seq_state_e;
endpackage

// File: rtl/scs_pulse_engine.sv
module scs_pulse_engine #(
  parameter int CNT_W = 12,
  parameter int TIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [TIM_W-1:0] hi_i,
  input  logic [TIM_W-1:0] lo_i,
  output logic             sclk_o,
  output logic             fall_o,
  output logic             done_o
);
  logic             active_q, sclk_q;
  logic [TIM_W-1:0] ph_q;
  logic [CNT_W-1:0] left_q;
  logic [TIM_W-1:0] hi_eff, lo_eff;

  assign hi_eff = (hi_i == '0) ? TIM_W'(1) : hi_i;
  assign lo_eff = (lo_i == '0) ? TIM_W'(1) : lo_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      ph_q     <= '0;
      left_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      sclk_q   <= 1'b1;
      ph_q     <= hi_eff - TIM_W'(1);
      left_q   <= count_i;
    end else if (active_q) begin
      if (ph_q != '0) begin
        ph_q <= ph_q - TIM_W'(1);
      end else if (sclk_q) begin
        sclk_q <= 1'b0;
        ph_q   <= lo_eff - TIM_W'(1);
      end else if (left_q == CNT_W'(1)) begin
        active_q <= 1'b0;
      end else begin
        left_q <= left_q - CNT_W'(1);
        sclk_q <= 1'b1;
        ph_q   <= hi_eff - TIM_W'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = active_q && sclk_q && (ph_q == '0);
  assign done_o = active_q && !sclk_q && (ph_q == '0) && (left_q == CNT_W'(1));

  // R3: the last high cycle is always followed by a low cycle
  p_fall_then_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !sclk_o);
endmodule

// File: rtl/scs_cfg_serializer.sv
module scs_cfg_serializer #(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [REG_W-1:0] word_i,
  input  logic             shift_i,
  output logic             sdata_o
);
  logic [REG_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[REG_W-2:0], 1'b0};
  end

  assign sdata_o = sh_q[REG_W-1];
endmodule

// File: rtl/scs_readout_tap.sv
module scs_readout_tap #(
  parameter int POS_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  output logic [POS_W-1:0] pos_o,
  output logic             valid_o,
  output logic             adc_o
);
  localparam int BIT_W = $clog2(POS_W + 1);

  logic             sclk_d, valid_q, adc_q;
  logic [BIT_W-1:0] bits_q;
  logic [POS_W-1:0] sh_q, pos_q;
  logic             rise, fall;

  assign rise = sclk_i && !sclk_d;
  assign fall = !sclk_i && sclk_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      adc_q   <= 1'b0;
      valid_q <= 1'b0;
      bits_q  <= '0;
      sh_q    <= '0;
      pos_q   <= '0;
    end else begin
      sclk_d  <= sclk_i;
      adc_q   <= en_i && fall;
      valid_q <= 1'b0;
      if (clear_i) begin
        bits_q <= '0;
      end else if (en_i && rise && bits_q != BIT_W'(POS_W)) begin
        sh_q   <= {sh_q[POS_W-2:0], sdata_i};
        bits_q <= bits_q + BIT_W'(1);
        if (bits_q == BIT_W'(POS_W - 1)) begin
          pos_q   <= {sh_q[POS_W-2:0], sdata_i};
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign pos_o   = pos_q;
  assign valid_o = valid_q;
  assign adc_o   = adc_q;

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_adc_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_o |-> ($past(sclk_i, 2) && !$past(sclk_i)));
endmodule

// File: rtl/scs_readout_seq.sv
module scs_readout_seq
  import scs_seq_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                REG_W     = 8,
  parameter int                POS_W     = 10,
  parameter int                CNT_W     = 12,
  parameter int                TIM_W     = 4,
  parameter int                LOAD_MIN  = 2,
  parameter logic [ADDR_W-1:0] ADDR_IDLE = 4'b0000,
  parameter logic [ADDR_W-1:0] ADDR_CFG  = 4'b1100,
  parameter logic [ADDR_W-1:0] ADDR_WSR  = 4'b1101,
  parameter logic [ADDR_W-1:0] ADDR_READ = 4'b1001,
  parameter logic [REG_W-1:0]  CFG_WORD  = 8'hFF,
  parameter logic [REG_W-1:0]  WSR_WORD  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic [TIM_W-1:0]  hi_cycles_i,
  input  logic [TIM_W-1:0]  lo_cycles_i,
  input  logic [TIM_W-1:0]  load_cycles_i,
  input  logic [CNT_W-1:0]  shift_count_i,
  input  logic              sdata_i,
  output logic [ADDR_W-1:0] chip_addr_o,
  output logic              run_o,
  output logic              write_o,
  output logic              stop_load_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              adc_conv_o,
  output logic              busy_o,
  output logic [POS_W-1:0]  stop_pos_o,
  output logic              stop_valid_o
);
  seq_state_e       state_q, state_d;
  logic [TIM_W-1:0] load_cnt_q, load_eff;
  logic [CNT_W-1:0] n_eff, eng_count;
  logic             eng_start, eng_fall, eng_done;
  logic             ser_load, ser_shift;
  logic [REG_W-1:0] ser_word;
  logic             cap_clear, in_cfg, in_read;

  assign load_eff = (load_cycles_i < TIM_W'(LOAD_MIN)) ? TIM_W'(LOAD_MIN) : load_cycles_i;
  assign n_eff    = (shift_count_i < CNT_W'(POS_W)) ? CNT_W'(POS_W) : shift_count_i;
  assign in_cfg   = (state_q == ST_CFG0) || (state_q == ST_CFG1);
  assign in_read  = (state_q == ST_READ);

  always_comb begin
    state_d   = state_q;
    eng_start = 1'b0;
    eng_count = CNT_W'(REG_W);
    ser_load  = 1'b0;
    ser_word  = CFG_WORD;
    cap_clear = 1'b0;
    case (state_q)
      ST_INIT: begin
        state_d   = ST_CFG0;
        eng_start = 1'b1;
        ser_load  = 1'b1;
      end
      ST_CFG0: if (eng_done) begin
        state_d   = ST_CFG1;
        eng_start = 1'b1;
        ser_load  = 1'b1;
        ser_word  = WSR_WORD;
      end
      ST_CFG1:   if (eng_done) state_d = ST_ARM;
      ST_ARM:    if (trig_i) state_d = ST_FREEZE;
      ST_FREEZE: state_d = ST_LOAD;
      ST_LOAD: if (load_cnt_q == '0) begin
        state_d   = ST_READ;
        eng_start = 1'b1;
        eng_count = n_eff;
        cap_clear = 1'b1;
      end
      ST_READ:   if (eng_done) state_d = ST_ARM;
      default:   state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_INIT;
      load_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FREEZE)    load_cnt_q <= load_eff - TIM_W'(1);
      else if (state_q == ST_LOAD) load_cnt_q <= load_cnt_q - TIM_W'(1);
    end
  end

  always_comb begin
    case (state_q)
      ST_CFG0: chip_addr_o = ADDR_CFG;
      ST_CFG1: chip_addr_o = ADDR_WSR;
      ST_READ: chip_addr_o = ADDR_READ;
      default: chip_addr_o = ADDR_IDLE;
    endcase
  end

  assign run_o       = (state_q == ST_ARM) || busy_o;
  assign write_o     = (state_q == ST_ARM);
  assign stop_load_o = (state_q == ST_LOAD);
  assign busy_o      = (state_q == ST_FREEZE) || (state_q == ST_LOAD) || in_read;
  assign ser_shift   = eng_fall && in_cfg;

  scs_pulse_engine #(.CNT_W(CNT_W), .TIM_W(TIM_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .start_i(eng_start), .count_i(eng_count),
    .hi_i(hi_cycles_i), .lo_i(lo_cycles_i),
    .sclk_o(sclk_o), .fall_o(eng_fall), .done_o(eng_done)
  );

  scs_cfg_serializer #(.REG_W(REG_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load_i(ser_load), .word_i(ser_word),
    .shift_i(ser_shift), .sdata_o(sdata_o)
  );

  scs_readout_tap #(.POS_W(POS_W)) u_tap (
    .clk(clk), .rst_n(rst_n), .clear_i(cap_clear), .en_i(in_read),
    .sclk_i(sclk_o), .sdata_i(sdata_i),
    .pos_o(stop_pos_o), .valid_o(stop_valid_o), .adc_o(adc_conv_o)
  );

  p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(chip_addr_o));
  p_load_after_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_load_o) |-> (!write_o && !$past(write_o) && $past(busy_o)));
  p_load_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_load_o) |-> $past(stop_load_o, 2));
  p_read_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && sclk_o) |-> (chip_addr_o == ADDR_READ));
  p_busy_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!write_o && run_o));
  p_no_adc_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_cfg |-> !adc_conv_o);
endmodule

// File: tb/test_scs_readout_seq.sv
module test_scs_readout_seq;
  localparam logic [7:0] W0 = 8'hB4;
  localparam logic [7:0] W1 = 8'h3C;

  logic        clk = 1'b0, rst_n = 1'b0, trig = 1'b0, sdi = 1'b0;
  logic [3:0]  hi = 4'd2, lo = 4'd1, lw = 4'd4;
  logic [11:0] ns = 12'd16;
  logic [3:0]  addr;
  logic        run, wr, sload, sclk, sdo, adc, busy, valid;
  logic [9:0]  pos;

  scs_readout_seq #(.CFG_WORD(W0), .WSR_WORD(W1)) i_scs_readout_seq (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .hi_cycles_i(hi), .lo_cycles_i(lo),
    .load_cycles_i(lw), .shift_count_i(ns), .sdata_i(sdi),
    .chip_addr_o(addr), .run_o(run), .write_o(wr), .stop_load_o(sload),
    .sclk_o(sclk), .sdata_o(sdo), .adc_conv_o(adc), .busy_o(busy),
    .stop_pos_o(pos), .stop_valid_o(valid)
  );

  always #4 clk = ~clk;

  int  n_tests = 0, n_fail = 0;
  bit  step_bad, finished = 0;
  bit  prev_clk = 0, adc_next = 0, val_next = 0;
  int  rise_k = 0;
  logic [9:0] pos_exp = '0, pos_hold = '0;

  task automatic chk(string tag, string nm, logic [15:0] a, logic [15:0] e);
    if (a !== e) begin
      step_bad = 1;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, a, e, $time);
    end
  endtask

  // one cycle of the reference model: compare at negedge, then advance model
  task automatic step(string tag, logic [3:0] ea, bit erun, bit ewr, bit eld,
                      bit eclk, bit ebusy, bit rd, bit din_chk, bit edin);
    @(negedge clk);
    n_tests++;
    step_bad = 0;
    if (val_next) pos_hold = pos_exp;
    chk(tag, "addr", 16'(addr), 16'(ea));
    chk(tag, "run", 16'(run), 16'(erun));
    chk(tag, "write", 16'(wr), 16'(ewr));
    chk(tag, "stop_load", 16'(sload), 16'(eld));
    chk(tag, "sclk", 16'(sclk), 16'(eclk));
    chk("R9", "busy", 16'(busy), 16'(ebusy));
    chk("R8", "adc_conv", 16'(adc), 16'(adc_next));
    chk("R7", "stop_valid", 16'(valid), 16'(val_next));
    chk("R7", "stop_pos", 16'(pos), 16'(pos_hold));
    if (din_chk) chk("R2", "sdata_o", 16'(sdo), 16'(edin));
    if (step_bad) n_fail++;
    adc_next = rd && !eclk && prev_clk;
    val_next = 0;
    if (rd && eclk && !prev_clk && rise_k < 10) begin
      sdi = pos_exp[9-rise_k];
      rise_k++;
      if (rise_k == 10) val_next = 1;
    end else begin
      sdi = ~sdi;
    end
    prev_clk = eclk;
  endtask

  function automatic int eff(int v, int m);
    return (v < m) ? m : v;
  endfunction

  task automatic setup_phase();
    int he = eff(hi, 1), le = eff(lo, 1);
    for (int r = 0; r < 2; r++) begin
      logic [7:0] w = (r == 0) ? W0 : W1;
      logic [3:0] a = (r == 0) ? 4'b1100 : 4'b1101;
      for (int b = 0; b < 8; b++) begin
        for (int h = 0; h < he; h++) step("R2", a, 0, 0, 0, 1, 0, 0, 1, w[7-b]);
        for (int l = 0; l < le; l++) step("R3", a, 0, 0, 0, 0, 0, 0, 0, 0);
      end
    end
  endtask

  task automatic acquire(string arm_tag, int arm_n, logic [3:0] h, logic [3:0] l,
                         logic [3:0] w, logic [11:0] n, logic [9:0] p,
                         bit trig_busy, bit keep_trig);
    int he, le, we, ne;
    hi = h; lo = l; lw = w; ns = n;
    he = eff(h, 1); le = eff(l, 1); we = eff(w, 2); ne = eff(n, 10);
    pos_exp = p; rise_k = 0;
    for (int i = 0; i < arm_n; i++) begin
      step(arm_tag, 4'b0000, 1, 1, 0, 0, 0, 0, 1, 0);
      trig = (i == arm_n - 1);
    end
    step("R4", 4'b0000, 1, 0, 0, 0, 1, 0, 1, 0);
    trig = trig_busy;
    for (int i = 0; i < we; i++) step("R5", 4'b0000, 1, 0, 1, 0, 1, 0, 1, 0);
    for (int k = 0; k < ne; k++) begin
      if (k == ne - 1 && !keep_trig) trig = 0;
      for (int i = 0; i < he; i++) step("R6", 4'b1001, 1, 0, 0, 1, 1, 1, 1, 0);
      for (int i = 0; i < le; i++) step("R3", 4'b1001, 1, 0, 0, 0, 1, 1, 1, 0);
    end
  endtask

  initial begin
    step("R1", 4'b0000, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R1", 4'b0000, 0, 0, 0, 0, 0, 0, 1, 0);
    rst_n = 1;
    setup_phase();
    acquire("R4", 3, 4'd2, 4'd3, 4'd4, 12'd16, 10'h2D5, 0, 0);
    // clamps, trigger held while busy and into the next wait state
    acquire("R10", 2, 4'd0, 4'd1, 4'd0, 12'd0, 10'h13A, 1, 1);
    // overlap: trailing converter strobe with a trigger in the first wait cycle
    acquire("R10", 1, 4'd1, 4'd1, 4'd1, 12'd5, 10'h001, 0, 0);
    acquire("R10", 2, 4'd3, 4'd2, 4'd3, 12'd12, 10'h200, 1, 0);
    for (int i = 0; i < 4; i++) step("R10", 4'b0000, 1, 1, 0, 0, 0, 0, 1, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule